// File: doc/BRIEF.md
# Integer Add/Subtract/Compare Unit

This block is the arithmetic slice of an integer execute stage in a 64-bit RISC datapath. It is purely combinational. Each cycle it takes operand A, a B operand and a 7-bit function code. B is either a register value or an 8-bit literal taken from the instruction. The block returns a 64-bit result, an overflow-fault flag and an illegal-function flag. Register writeback, trap delivery and operand forwarding live in the surrounding pipeline.

The supported operations fall into four groups. The first is add and subtract in a 64-bit (quad) form and a 32-bit (long) form. The long form works on the low halves and sign-extends its result. The second is the scaled forms, which shift A left by two or three bit positions before the add or subtract. The third is the trapping forms, which raise a fault on signed overflow. The last is compares, which return a single truth bit, and a per-byte unsigned compare, which returns an eight-bit mask.

Top module: `ascmp_unit`

## Requirements
- R1: Function 0x20 returns A+B and 0x29 returns A-B, both modulo 2^64.
- R2: Scaled quad forms: 0x22 gives (A<<2)+B, 0x32 gives (A<<3)+B, 0x2B gives (A<<2)-B and 0x3B gives (A<<3)-B, all modulo 2^64. The long scaled forms 0x02, 0x12, 0x0B and 0x1B do the same on the low 32 bits and follow R3.
- R3: Long forms (0x00 add, 0x09 sub, and the long scaled codes) use only bits 31:0 of A and B. They compute a 32-bit result, and result bits 63:32 are copies of result bit 31.
- R4: Trapping adds 0x40 (long) and 0x60 (quad) return the same result as 0x00 and 0x20. They assert ovf_fault when A and B have the same sign bit and the result's sign bit differs from A's. The sign bit is bit 31 for the long form and bit 63 for the quad form.
- R5: Trapping subtracts 0x49 (long) and 0x69 (quad) return the same result as 0x09 and 0x29. They assert ovf_fault when A and B have different sign bits and the result's sign bit differs from A's, using the same sign-bit positions as R4.
- R6: ovf_fault is 0 for every function code other than 0x40, 0x60, 0x49 and 0x69, even when the arithmetic wraps.
- R7: Compares return 1 when the test holds and 0 otherwise, with bits 63:1 zero. The codes are 0x2D for A==B, 0x6D for signed A<=B, 0x4D for signed A<B, 0x3D for unsigned A<=B and 0x1D for unsigned A<B.
- R8: Function 0x0F sets result bit i (i=0..7) when unsigned byte i of A (bits 8i+7:8i) is greater than or equal to byte i of B. Result bits 63:8 are zero.
- R9: When use_lit is 1, B is lit_b zero-extended to 64 bits and reg_b has no effect on any output. When use_lit is 0, B is reg_b.
- R10: Any function code not listed in R1 to R8 gives result 0, ovf_fault 0 and bad_func 1. bad_func is 0 for every listed code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 64 | Operand A |
| reg_b | input | 64 | Register-sourced B operand |
| lit_b | input | 8 | Literal B operand, zero-extended when selected |
| use_lit | input | 1 | 1 selects lit_b as B, 0 selects reg_b |
| func | input | 7 | Function code |
| result | output | 64 | Operation result |
| ovf_fault | output | 1 | Signed overflow on a trapping form |
| bad_func | output | 1 | Function code not recognised |

## Verification
The hardest cases to reach are the overflow boundaries of the long trapping forms. There, bits 63:32 of the operands must be ignored, yet a carry into bit 31 must still be judged by the sign rule that fits the operation. A random operand seldom lands on them. The stimulus therefore drives directed pairs at the edges of the signed range, such as the largest positive value plus one and the most negative value minus one. These pairs carry junk in the upper halves, and each is also run through the non-trapping code to show that the fault stays silent. A sweep of all 128 function codes and seeded random operands over every legal code complete the coverage.

// File: rtl/ascmp_pkg.sv
package ascmp_pkg;

    localparam int FN_W = 7;

    // Function codes (decoded by the instruction front end)
    localparam logic [FN_W-1:0] FN_ADD32    = 7'h00;
    localparam logic [FN_W-1:0] FN_ADD32_T  = 7'h40;
    localparam logic [FN_W-1:0] FN_SC4ADD32 = 7'h02;
    localparam logic [FN_W-1:0] FN_SC8ADD32 = 7'h12;
    localparam logic [FN_W-1:0] FN_ADD64    = 7'h20;
    localparam logic [FN_W-1:0] FN_ADD64_T  = 7'h60;
    localparam logic [FN_W-1:0] FN_SC4ADD64 = 7'h22;
    localparam logic [FN_W-1:0] FN_SC8ADD64 = 7'h32;
    localparam logic [FN_W-1:0] FN_SUB32    = 7'h09;
    localparam logic [FN_W-1:0] FN_SUB32_T  = 7'h49;
    localparam logic [FN_W-1:0] FN_SC4SUB32 = 7'h0B;
    localparam logic [FN_W-1:0] FN_SC8SUB32 = 7'h1B;
    localparam logic [FN_W-1:0] FN_SUB64    = 7'h29;
    localparam logic [FN_W-1:0] FN_SUB64_T  = 7'h69;
    localparam logic [FN_W-1:0] FN_SC4SUB64 = 7'h2B;
    localparam logic [FN_W-1:0] FN_SC8SUB64 = 7'h3B;
    localparam logic [FN_W-1:0] FN_CMP_EQ   = 7'h2D;
    localparam logic [FN_W-1:0] FN_CMP_SLE  = 7'h6D;
    localparam logic [FN_W-1:0] FN_CMP_SLT  = 7'h4D;
    localparam logic [FN_W-1:0] FN_CMP_ULE  = 7'h3D;
    localparam logic [FN_W-1:0] FN_CMP_ULT  = 7'h1D;
    localparam logic [FN_W-1:0] FN_BYTE_GE  = 7'h0F;

    typedef enum logic [1:0] {
        GRP_ARITH,
        GRP_CMP,
        GRP_BYTES,
        GRP_NONE
    } grp_e;

    typedef enum logic [2:0] {
        CMP_EQ,
        CMP_SLE,
        CMP_SLT,
        CMP_ULE,
        CMP_ULT
    } cmp_e;

    typedef struct packed {
        grp_e       grp;
        logic       sub;     // subtract instead of add
        logic [1:0] shamt;   // left shift applied to A
        logic       narrow;  // 32-bit form
        logic       trap;    // overflow raises a fault
        cmp_e       cmp;
    } ctl_t;

    function automatic ctl_t arith_ctl(logic sub, logic [1:0] shamt,
                                       logic narrow, logic trap);
        ctl_t c;
        c.grp    = GRP_ARITH;
        c.sub    = sub;
        c.shamt  = shamt;
        c.narrow = narrow;
        c.trap   = trap;
        c.cmp    = CMP_EQ;
        return c;
    endfunction

    function automatic ctl_t cmp_ctl(grp_e g, cmp_e k);
        ctl_t c;
        c.grp    = g;
        c.sub    = 1'b0;
        c.shamt  = 2'd0;
        c.narrow = 1'b0;
        c.trap   = 1'b0;
        c.cmp    = k;
        return c;
    endfunction

    function automatic ctl_t decode_fn(logic [FN_W-1:0] f);
        ctl_t c;
        case (f)
            FN_ADD32:    c = arith_ctl(1'b0, 2'd0, 1'b1, 1'b0);
            FN_ADD32_T:  c = arith_ctl(1'b0, 2'd0, 1'b1, 1'b1);
            FN_SC4ADD32: c = arith_ctl(1'b0, 2'd2, 1'b1, 1'b0);
            FN_SC8ADD32: c = arith_ctl(1'b0, 2'd3, 1'b1, 1'b0);
            FN_ADD64:    c = arith_ctl(1'b0, 2'd0, 1'b0, 1'b0);
            FN_ADD64_T:  c = arith_ctl(1'b0, 2'd0, 1'b0, 1'b1);
            FN_SC4ADD64: c = arith_ctl(1'b0, 2'd2, 1'b0, 1'b0);
            FN_SC8ADD64: c = arith_ctl(1'b0, 2'd3, 1'b0, 1'b0);
            FN_SUB32:    c = arith_ctl(1'b1, 2'd0, 1'b1, 1'b0);
            FN_SUB32_T:  c = arith_ctl(1'b1, 2'd0, 1'b1, 1'b1);
            FN_SC4SUB32: c = arith_ctl(1'b1, 2'd2, 1'b1, 1'b0);
            FN_SC8SUB32: c = arith_ctl(1'b1, 2'd3, 1'b1, 1'b0);
            FN_SUB64:    c = arith_ctl(1'b1, 2'd0, 1'b0, 1'b0);
            FN_SUB64_T:  c = arith_ctl(1'b1, 2'd0, 1'b0, 1'b1);
            FN_SC4SUB64: c = arith_ctl(1'b1, 2'd2, 1'b0, 1'b0);
            FN_SC8SUB64: c = arith_ctl(1'b1, 2'd3, 1'b0, 1'b0);
            FN_CMP_EQ:   c = cmp_ctl(GRP_CMP, CMP_EQ);
            FN_CMP_SLE:  c = cmp_ctl(GRP_CMP, CMP_SLE);
            FN_CMP_SLT:  c = cmp_ctl(GRP_CMP, CMP_SLT);
            FN_CMP_ULE:  c = cmp_ctl(GRP_CMP, CMP_ULE);
            FN_CMP_ULT:  c = cmp_ctl(GRP_CMP, CMP_ULT);
            FN_BYTE_GE:  c = cmp_ctl(GRP_BYTES, CMP_EQ);
            default:     c = cmp_ctl(GRP_NONE, CMP_EQ);
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ascmp_decode.sv
module ascmp_decode
    import ascmp_pkg::*;
(
    input  logic [FN_W-1:0] func,
    output ctl_t            ctl
);
    always_comb ctl = decode_fn(func);
endmodule

// File: rtl/ascmp_adder.sv
module ascmp_adder
    import ascmp_pkg::*;
#(
    parameter int W  = 64,
    parameter int NW = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  ctl_t         ctl,
    output logic [W-1:0] sum,
    output logic         ovf
);
    localparam int EXT = W - NW;

    logic [W-1:0] a_sh;
    logic [W-1:0] b_eff;
    logic [W-1:0] raw;
    logic         sa, sb, sr;

    always_comb begin
        a_sh  = a << ctl.shamt;
        b_eff = ctl.sub ? ~b : b;
        raw   = a_sh + b_eff + W'(ctl.sub);

        if (ctl.narrow) begin
            sum = {{EXT{raw[NW-1]}}, raw[NW-1:0]};
            sa  = a[NW-1];
            sb  = b[NW-1];
            sr  = raw[NW-1];
        end else begin
            sum = raw;
            sa  = a[W-1];
            sb  = b[W-1];
            sr  = raw[W-1];
        end

        // add: like signs, result flips; sub: unlike signs, result flips
        ovf = ctl.trap && (ctl.sub ? (sa != sb) : (sa == sb)) && (sr != sa);
    end
endmodule

// File: rtl/ascmp_compare.sv
module ascmp_compare
    import ascmp_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  cmp_e           sel,
    output logic           flag,
    output logic [W/8-1:0] lane_ge
);
    localparam int NB = W / 8;

    logic eq, slt, ult;

    always_comb begin
        eq  = (a == b);
        slt = ($signed(a) < $signed(b));
        ult = (a < b);
        case (sel)
            CMP_EQ:  flag = eq;
            CMP_SLE: flag = slt | eq;
            CMP_SLT: flag = slt;
            CMP_ULE: flag = ult | eq;
            CMP_ULT: flag = ult;
            default: flag = 1'b0;
        endcase
    end

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign lane_ge[i] = (a[8*i +: 8] >= b[8*i +: 8]);
    end
endmodule

// File: rtl/ascmp_unit.sv
module ascmp_unit
    import ascmp_pkg::*;
#(
    parameter int W   = 64,
    parameter int NW  = 32,
    parameter int LIT = 8
) (
    input  logic [W-1:0]    opnd_a,
    input  logic [W-1:0]    reg_b,
    input  logic [LIT-1:0]  lit_b,
    input  logic            use_lit,
    input  logic [FN_W-1:0] func,
    output logic [W-1:0]    result,
    output logic            ovf_fault,
    output logic            bad_func
);
    localparam int NB = W / 8;

    ctl_t           ctl;
    logic [W-1:0]   b_op;
    logic [W-1:0]   sum;
    logic           ovf;
    logic           flag;
    logic [NB-1:0]  lane_ge;

    assign b_op = use_lit ? {{(W-LIT){1'b0}}, lit_b} : reg_b;

    ascmp_decode u_dec (
        .func (func),
        .ctl  (ctl)
    );

    ascmp_adder #(.W(W), .NW(NW)) u_add (
        .a   (opnd_a),
        .b   (b_op),
        .ctl (ctl),
        .sum (sum),
        .ovf (ovf)
    );

    ascmp_compare #(.W(W)) u_cmp (
        .a       (opnd_a),
        .b       (b_op),
        .sel     (ctl.cmp),
        .flag    (flag),
        .lane_ge (lane_ge)
    );

    always_comb begin
        ovf_fault = 1'b0;
        bad_func  = 1'b0;
        case (ctl.grp)
            GRP_ARITH: begin
                result    = sum;
                ovf_fault = ovf;
            end
            GRP_CMP:   result = {{(W-1){1'b0}}, flag};
            GRP_BYTES: result = {{(W-NB){1'b0}}, lane_ge};
            default: begin
                result   = '0;
                bad_func = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ascmp_chk.sv
module ascmp_chk #(
    parameter int W   = 64,
    parameter int LIT = 8
) (
    input logic [W-1:0]   opnd_a,
    input logic [W-1:0]   reg_b,
    input logic [LIT-1:0] lit_b,
    input logic           use_lit,
    input logic [6:0]     func,
    input logic [W-1:0]   result,
    input logic           ovf_fault,
    input logic           bad_func
);
    logic is_cmp, is_trap, is_long;

    always_comb begin
        is_cmp  = func inside {7'h2D, 7'h6D, 7'h4D, 7'h3D, 7'h1D};
        is_trap = func inside {7'h40, 7'h60, 7'h49, 7'h69};
        is_long = func inside {7'h00, 7'h40, 7'h02, 7'h12,
                               7'h09, 7'h49, 7'h0B, 7'h1B};

        if (bad_func)
            AST_BAD_ZERO: assert (result == '0 && !ovf_fault) else $error("bad code output"); // R10
        if (ovf_fault)
            AST_FAULT_TRAP_ONLY: assert (is_trap) else $error("fault on non-trap code"); // R6
        if (is_cmp)
            AST_CMP_BOOL: assert (result[W-1:1] == '0) else $error("compare not boolean"); // R7
        if (func == 7'h0F)
            AST_BYTE_MASK: assert (result[W-1:8] == '0) else $error("byte mask high bits"); // R8
        if (is_long)
            AST_LONG_SEXT: assert (result[W-1:32] == {(W-32){result[31]}}) else $error("long not sign-extended"); // R3
        if (use_lit && func == 7'h2D)
            AST_LIT_ZEXT: assert (result[0] == (opnd_a == {{(W-LIT){1'b0}}, lit_b})) else $error("literal not zero-extended"); // R9
    end
endmodule

bind ascmp_unit ascmp_chk #(.W(W), .LIT(LIT)) u_chk (.*);

// File: tb/ascmp_unit_tb.sv
`timescale 1ns/1ps
module ascmp_unit_tb;

    logic        clk = 1'b0;
    logic [63:0] opnd_a = '0;
    logic [63:0] reg_b = '0;
    logic [7:0]  lit_b = '0;
    logic        use_lit = 1'b0;
    logic [6:0]  func = 7'h00;
    logic [63:0] result;
    logic        ovf_fault;
    logic        bad_func;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ascmp_unit u_dut (
        .opnd_a    (opnd_a),
        .reg_b     (reg_b),
        .lit_b     (lit_b),
        .use_lit   (use_lit),
        .func      (func),
        .result    (result),
        .ovf_fault (ovf_fault),
        .bad_func  (bad_func)
    );

    typedef struct {
        logic [63:0] res;
        logic        ovf;
        logic        bad;
        string       tag;
    } exp_t;

    exp_t sb_q[$];

    localparam logic [6:0] LEGAL [22] = '{
        7'h00, 7'h40, 7'h02, 7'h12, 7'h20, 7'h60, 7'h22, 7'h32,
        7'h09, 7'h49, 7'h0B, 7'h1B, 7'h29, 7'h69, 7'h2B, 7'h3B,
        7'h2D, 7'h6D, 7'h4D, 7'h3D, 7'h1D, 7'h0F};

    function automatic logic [63:0] sx32(logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    // Reference model built from the requirement text
    function automatic exp_t model(logic [6:0] f, logic [63:0] a, logic [63:0] b);
        exp_t e;
        logic [64:0] w;
        logic [32:0] n;
        e.res = '0; e.ovf = 1'b0; e.bad = 1'b0; e.tag = "R1";
        case (f)
            7'h20: e.res = a + b;
            7'h29: e.res = a - b;
            7'h22: begin e.res = (a * 4) + b; e.tag = "R2"; end
            7'h32: begin e.res = (a * 8) + b; e.tag = "R2"; end
            7'h2B: begin e.res = (a * 4) - b; e.tag = "R2"; end
            7'h3B: begin e.res = (a * 8) - b; e.tag = "R2"; end
            7'h00: begin e.res = sx32(a[31:0] + b[31:0]); e.tag = "R3"; end
            7'h09: begin e.res = sx32(a[31:0] - b[31:0]); e.tag = "R3"; end
            7'h02: begin e.res = sx32(a[31:0] * 4 + b[31:0]); e.tag = "R3"; end
            7'h12: begin e.res = sx32(a[31:0] * 8 + b[31:0]); e.tag = "R3"; end
            7'h0B: begin e.res = sx32(a[31:0] * 4 - b[31:0]); e.tag = "R3"; end
            7'h1B: begin e.res = sx32(a[31:0] * 8 - b[31:0]); e.tag = "R3"; end
            7'h60: begin
                w = {a[63], a} + {b[63], b};
                e.res = w[63:0]; e.ovf = (w[64] != w[63]); e.tag = "R4";
            end
            7'h40: begin
                n = {a[31], a[31:0]} + {b[31], b[31:0]};
                e.res = sx32(n[31:0]); e.ovf = (n[32] != n[31]); e.tag = "R4";
            end
            7'h69: begin
                w = {a[63], a} - {b[63], b};
                e.res = w[63:0]; e.ovf = (w[64] != w[63]); e.tag = "R5";
            end
            7'h49: begin
                n = {a[31], a[31:0]} - {b[31], b[31:0]};
                e.res = sx32(n[31:0]); e.ovf = (n[32] != n[31]); e.tag = "R5";
            end
            7'h2D: begin e.res = 64'(a == b); e.tag = "R7"; end
            7'h6D: begin e.res = 64'($signed(a) <= $signed(b)); e.tag = "R7"; end
            7'h4D: begin e.res = 64'($signed(a) < $signed(b)); e.tag = "R7"; end
            7'h3D: begin e.res = 64'(a <= b); e.tag = "R7"; end
            7'h1D: begin e.res = 64'(a < b); e.tag = "R7"; end
            7'h0F: begin
                for (int i = 0; i < 8; i++)
                    e.res[i] = (a[8*i +: 8] >= b[8*i +: 8]);
                e.tag = "R8";
            end
            default: begin e.bad = 1'b1; e.tag = "R10"; end
        endcase
        return e;
    endfunction

    // Driver: applies a vector at a rising edge and queues the expectation
    task automatic drive(input logic [6:0] f, input logic [63:0] a,
                         input logic [63:0] rb, input logic [7:0] l,
                         input logic ul, input string tag);
        exp_t e;
        @(posedge clk);
        func = f; opnd_a = a; reg_b = rb; lit_b = l; use_lit = ul;
        e = model(f, a, ul ? {56'b0, l} : rb);
        if (tag != "") e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compares at the falling edge, after the inputs settled
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (result !== e.res || ovf_fault !== e.ovf || bad_func !== e.bad) begin
                errors++;
                $display("FAIL %s func=%h got res=%h ovf=%b bad=%b exp res=%h ovf=%b bad=%b",
                         e.tag, func, result, ovf_fault, bad_func, e.res, e.ovf, e.bad);
            end
        end
    end

    initial begin
        logic [63:0] x;
        x = 64'h9E37_79B9_7F4A_7C15;
        // reset-state check: all-zero inputs with code 0x00 (R3)
        drive(7'h00, 64'h0, 64'h0, 8'h0, 1'b0, "R3");
        // R1 plain quad add/sub with wrap
        drive(7'h20, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 8'h0, 1'b0, "R1");
        drive(7'h29, 64'h0, 64'h1, 8'h0, 1'b0, "R1");
        // R2 scaled forms
        drive(7'h22, 64'h4000_0000_0000_0003, 64'h10, 8'h0, 1'b0, "R2");
        drive(7'h3B, 64'h2000_0000_0000_0001, 64'h9, 8'h0, 1'b0, "R2");
        drive(7'h12, 64'hFFFF_0000_1000_0001, 64'h5, 8'h0, 1'b0, "R2");
        // R3 long forms ignore upper halves
        drive(7'h00, 64'hDEAD_BEEF_7FFF_FFFF, 64'h1234_5678_0000_0001, 8'h0, 1'b0, "R3");
        drive(7'h09, 64'hAAAA_AAAA_0000_0000, 64'h5555_5555_0000_0001, 8'h0, 1'b0, "R3");
        // R4 trapping add boundaries
        drive(7'h60, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 8'h0, 1'b0, "R4");
        drive(7'h60, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0, 1'b0, "R4");
        drive(7'h60, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 8'h0, 1'b0, "R4");
        drive(7'h40, 64'hDEAD_0000_7FFF_FFFF, 64'hFFFF_FFFF_0000_0001, 8'h0, 1'b0, "R4");
        drive(7'h40, 64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0, 1'b0, "R4");
        // R5 trapping subtract boundaries
        drive(7'h69, 64'h8000_0000_0000_0000, 64'h1, 8'h0, 1'b0, "R5");
        drive(7'h69, 64'h0, 64'h8000_0000_0000_0000, 8'h0, 1'b0, "R5");
        drive(7'h69, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 8'h0, 1'b0, "R5");
        drive(7'h49, 64'h1111_1111_8000_0000, 64'h0000_0000_0000_0001, 8'h0, 1'b0, "R5");
        drive(7'h49, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_FFFF_FFFF, 8'h0, 1'b0, "R5");
        // R6 non-trapping forms stay silent on overflow
        drive(7'h20, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 8'h0, 1'b0, "R6");
        drive(7'h09, 64'h0000_0000_8000_0000, 64'h1, 8'h0, 1'b0, "R6");
        drive(7'h22, 64'h7000_0000_0000_0000, 64'h0, 8'h0, 1'b0, "R6");
        // R7 compares: signed vs unsigned disagreement and equality
        drive(7'h4D, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 8'h0, 1'b0, "R7");
        drive(7'h1D, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 8'h0, 1'b0, "R7");
        drive(7'h6D, 64'h42, 64'h42, 8'h0, 1'b0, "R7");
        drive(7'h3D, 64'h42, 64'h41, 8'h0, 1'b0, "R7");
        drive(7'h2D, 64'h42, 64'h42, 8'h0, 1'b0, "R7");
        // R8 byte compare
        drive(7'h0F, 64'h00FF_7F80_1000_FF01, 64'h0100_7F81_0F00_FF02, 8'h0, 1'b0, "R8");
        drive(7'h0F, 64'h0, 64'h0, 8'h0, 1'b0, "R8");
        // R9 literal selection, register value must not matter
        drive(7'h20, 64'h100, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 1'b1, "R9");
        drive(7'h2D, 64'hFF, 64'h0, 8'hFF, 1'b1, "R9");
        drive(7'h1D, 64'h80, 64'hFFFF_FFFF_FFFF_FFFF, 8'h80, 1'b1, "R9");
        drive(7'h0F, 64'h0000_0000_0000_0010, 64'h0, 8'h20, 1'b1, "R9");
        // R10 sweep of every code; model tags illegal codes R10
        for (int k = 0; k < 128; k++)
            drive(7'(k), 64'hFEDC_BA98_7654_3210, 64'h0123_4567_89AB_CDEF, 8'h0, 1'b0, "");
        // Seeded random vectors over legal codes
        for (int k = 0; k < 300; k++) begin
            logic [63:0] ra, rb;
            x ^= x << 13; x ^= x >> 7; x ^= x << 17; ra = x;
            x ^= x << 13; x ^= x >> 7; x ^= x << 17; rb = x;
            drive(LEGAL[k % 22], ra, rb, rb[15:8], rb[3] & rb[40], "");
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule